// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Nibble Flags

This block is the arithmetic and logic unit of a small accumulator machine. Each cycle it takes a 4-bit operation select, the accumulator value, a second operand and the current four status flags (zero, subtract, half-carry, carry). It returns a result byte and a packed flag byte in the same cycle. Binary add and subtract come with and without the incoming carry, and there is a compare that only touches flags. The unary operations are increment, decrement and a decimal correction after BCD arithmetic. Bitwise AND, OR and XOR complete the set.

A thin registered stage sits around the combinational core. When the write enable is high at a clock edge, the result is captured into an accumulator register and the flag byte into a flag register. When the enable is low, both registers hold their values. The surrounding CPU supplies the operands and the flags and decides when to write back.

Top module: `acc_alu_unit`

## Requirements
- R1: Operation select 0 (add): result = A+B mod 256. Half-carry is set when the low nibbles sum above 0xF. Carry is set on 8-bit overflow. Subtract is cleared and zero reflects the result.
- R2: Select 1 (add with carry): result = A+B+Cin mod 256. Half-carry is set when A[3:0]+B[3:0]+Cin exceeds 0xF. Carry is set when the full 9-bit sum exceeds 0xFF. Subtract is cleared and zero reflects the result.
- R3: Select 2 (subtract) and select 4 (compare): subtract is set. Half-carry is set when B[3:0] > A[3:0], carry is set when B > A, and zero reflects A-B. Subtract writes A-B to the result, while compare returns A unchanged.
- R4: Select 3 (subtract with borrow): result = A-B-Cin mod 256. Carry is set when B+Cin > A. Half-carry is set when B[3:0]+Cin > A[3:0]. Subtract is set and zero reflects the result.
- R5: Select 5 (increment) and select 6 (decrement) return A+1 and A-1 mod 256 and never change carry. Increment clears subtract and sets half-carry exactly when A[3:0] = 0xF. Decrement sets subtract and sets half-carry exactly when A[3:0] = 0.
- R6: Select 7 (decimal adjust) with the incoming subtract flag set: 0x06 is subtracted if half-carry is in, 0x60 is subtracted if carry is in, and carry and subtract pass through unchanged.
- R7: Select 7 with the incoming subtract flag clear: 0x06 is added if half-carry is in or A[3:0] > 9. 0x60 is added if carry is in or A > 0x99, and carry out is set exactly in that case. Subtract stays clear.
- R8: Decimal adjust always clears half-carry and sets zero exactly when the result is 0.
- R9: Select 8 (AND) sets half-carry. Selects 9 (OR) and 10 (XOR) clear it. All three clear subtract and carry and set zero from the result.
- R10: The input flag nibble holds zero in bit 3, subtract in bit 2, half-carry in bit 1 and carry in bit 0. The output flag byte holds them in bits 7, 6, 5 and 4, and its bits 3..0 always read 0.
- R11: Selects 11 to 15 return A unchanged and copy the input flags unchanged into the upper nibble of the output.
- R12: With the write enable high at a rising clock edge, the accumulator and flag registers take the result and the flag byte. With it low, both keep their values.
- R13: After reset the accumulator and flag registers read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Write-back enable for the output registers |
| op | input | 4 | Operation select |
| a_in | input | 8 | Accumulator operand |
| b_in | input | 8 | Second operand |
| flags_in | input | 4 | Incoming flags {zero, subtract, half-carry, carry} |
| result | output | 8 | Combinational result byte |
| flags_out | output | 8 | Combinational flag byte, flags in bits 7..4 |
| acc_q | output | 8 | Registered accumulator |
| flag_q | output | 8 | Registered flag byte |

## Verification
Decimal adjust is where two corrections fall on the same operation. In add mode the low-nibble +0x06 and the high +0x60 can both apply, and in subtract mode both subtractions can apply. The same holds for the two carry sources of add-with-carry and subtract-with-borrow, the operand step and the carry-in step. The bench sweeps every accumulator value against every flag nibble for decimal adjust. For the carry-using binary operations it pairs every accumulator value with a spread of operands and both carry-in values, so that both steps wrap together. Every result and flag byte is compared with an independent model, and the enable is dropped on a fixed cadence so that holding and writing are judged on the same stream of operations.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_CMP = 4'd4,
        OP_INC = 4'd5,
        OP_DEC = 4'd6,
        OP_DAA = 4'd7,
        OP_AND = 4'd8,
        OP_OR  = 4'd9,
        OP_XOR = 4'd10
    } alu_op_e;

    localparam logic [3:0] OP_LAST = 4'd10;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    function automatic logic [DATA_W-1:0] pack_flags(input flags_t f);
        return {f, {NIB_W{1'b0}}};
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_pkg::*;
(
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  flags_t            fi,
    output logic [DATA_W-1:0] y,
    output flags_t            fo
);

    logic              cin;
    logic [DATA_W:0]   wide;
    logic [NIB_W:0]    lo;

    always_comb begin
        cin  = ((op == OP_ADC) || (op == OP_SBC)) ? fi.c : 1'b0;
        wide = '0;
        lo   = '0;
        y    = a;
        fo   = fi;
        case (op)
            OP_ADD, OP_ADC: begin
                wide = {1'b0, a} + {1'b0, b} + (DATA_W+1)'(cin);
                lo   = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + (NIB_W+1)'(cin);
                y    = wide[DATA_W-1:0];
                fo.z = (y == '0);
                fo.n = 1'b0;
                fo.h = lo[NIB_W];
                fo.c = wide[DATA_W];
            end
            OP_SUB, OP_SBC, OP_CMP: begin
                wide = {1'b0, a} - {1'b0, b} - (DATA_W+1)'(cin);
                lo   = {1'b0, a[NIB_W-1:0]} - {1'b0, b[NIB_W-1:0]} - (NIB_W+1)'(cin);
                y    = (op == OP_CMP) ? a : wide[DATA_W-1:0];
                fo.z = (wide[DATA_W-1:0] == '0);
                fo.n = 1'b1;
                fo.h = lo[NIB_W];
                fo.c = wide[DATA_W];
            end
            OP_INC: begin
                y    = a + 1'b1;
                fo.z = (y == '0);
                fo.n = 1'b0;
                fo.h = (a[NIB_W-1:0] == {NIB_W{1'b1}});
            end
            OP_DEC: begin
                y    = a - 1'b1;
                fo.z = (y == '0);
                fo.n = 1'b1;
                fo.h = (a[NIB_W-1:0] == '0);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/alu_bcd_adj.sv
module alu_bcd_adj
    import alu_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  flags_t            fi,
    output logic [DATA_W-1:0] y,
    output flags_t            fo
);

    localparam logic [DATA_W-1:0] FIX_LO   = 8'h06;
    localparam logic [DATA_W-1:0] FIX_HI   = 8'h60;
    localparam logic [DATA_W-1:0] BCD_MAX  = 8'h99;
    localparam logic [NIB_W-1:0]  DIGIT_MX = 4'd9;

    logic [DATA_W-1:0] corr;

    always_comb begin
        corr = '0;
        fo   = fi;
        if (fi.n) begin
            if (fi.h) corr = corr | FIX_LO;
            if (fi.c) corr = corr | FIX_HI;
            y = a - corr;
        end else begin
            if (fi.h || (a[NIB_W-1:0] > DIGIT_MX)) corr = corr | FIX_LO;
            if (fi.c || (a > BCD_MAX)) begin
                corr = corr | FIX_HI;
                fo.c = 1'b1;
            end
            y = a + corr;
        end
        fo.z = (y == '0);
        fo.h = 1'b0;
    end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import alu_pkg::*;
(
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y,
    output flags_t            fo
);

    always_comb begin
        case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            default: y = a ^ b;
        endcase
        fo.z = (y == '0);
        fo.n = 1'b0;
        fo.h = (op == OP_AND);
        fo.c = 1'b0;
    end

endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
    import alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic [NIB_W-1:0]  flags_in,
    output logic [DATA_W-1:0] result,
    output logic [DATA_W-1:0] flags_out,
    output logic [DATA_W-1:0] acc_q,
    output logic [DATA_W-1:0] flag_q
);

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] flg;
    } wb_state_t;

    flags_t            fi;
    logic [DATA_W-1:0] y_as, y_bcd, y_bit;
    flags_t            f_as, f_bcd, f_bit;
    flags_t            f_sel;
    wb_state_t         st_d, st_q;

    assign fi = flags_t'(flags_in);

    alu_addsub u_addsub (
        .op (op), .a (a_in), .b (b_in), .fi (fi), .y (y_as), .fo (f_as)
    );

    alu_bcd_adj u_bcd (
        .a (a_in), .fi (fi), .y (y_bcd), .fo (f_bcd)
    );

    alu_bitwise u_bit (
        .op (op), .a (a_in), .b (b_in), .y (y_bit), .fo (f_bit)
    );

    always_comb begin
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_INC, OP_DEC: begin
                result = y_as;
                f_sel  = f_as;
            end
            OP_DAA: begin
                result = y_bcd;
                f_sel  = f_bcd;
            end
            OP_AND, OP_OR, OP_XOR: begin
                result = y_bit;
                f_sel  = f_bit;
            end
            default: begin
                result = a_in;
                f_sel  = fi;
            end
        endcase
        flags_out = pack_flags(f_sel);
    end

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.acc = result;
            st_d.flg = flags_out;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_q  = st_q.acc;
    assign flag_q = st_q.flg;

    AST_WRITE_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (acc_q == $past(result)) && (flag_q == $past(flags_out))); // R12
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(acc_q) && $stable(flag_q)); // R12
    AST_STEP_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_INC) || (op == OP_DEC)) |-> (flags_out[4] == flags_in[0])); // R5
    AST_CMP_KEEPS_A: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CMP) |-> (result == a_in) && flags_out[6]); // R3
    AST_BCD_HALF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DAA) |-> !flags_out[5] && (flags_out[7] == (result == '0))); // R8
    AST_FLAG_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q[3:0] == '0); // R10
    AST_SPARE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (op > OP_LAST) |-> (result == a_in) && (flags_out[7:4] == flags_in)); // R11

endmodule

// File: tb/acc_alu_unit_bench.sv
module acc_alu_unit_bench;

    typedef struct {
        logic [3:0] op;
        logic [7:0] a;
        logic [7:0] b;
        logic [3:0] fl;
        logic [7:0] y;
        logic [7:0] f;
        logic [7:0] acc;
        logic [7:0] flg;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [3:0] op = 4'd0;
    logic [7:0] a_in = 8'd0;
    logic [7:0] b_in = 8'd0;
    logic [3:0] flags_in = 4'd0;
    logic [7:0] result, flags_out, acc_q, flag_q;

    int    checks = 0;
    int    errors = 0;
    item_t q[$];
    logic [7:0] acc_m = 8'd0;
    logic [7:0] flg_m = 8'd0;
    int    sent = 0;
    int    seen = 0;
    bit    done = 1'b0;

    always #5 clk = ~clk;

    acc_alu_unit u_acc_alu_unit (
        .clk (clk), .rst_n (rst_n), .en (en), .op (op),
        .a_in (a_in), .b_in (b_in), .flags_in (flags_in),
        .result (result), .flags_out (flags_out),
        .acc_q (acc_q), .flag_q (flag_q)
    );

    // Reference model built from the requirements; returns {result, flag byte}
    function automatic logic [15:0] ref_calc(input logic [3:0] o, input logic [7:0] a,
                                             input logic [7:0] b, input logic [3:0] fl);
        int ai = a, bi = b, ci = fl[0], v = 0, corr = 0;
        logic z, n, h, c;
        z = fl[3]; n = fl[2]; h = fl[1]; c = fl[0];
        case (o)
            4'd0, 4'd1: begin
                if (o == 4'd0) ci = 0;
                v = ai + bi + ci;
                h = ((ai % 16) + (bi % 16) + ci) > 15;
                c = v > 255; n = 0; v = v % 256; z = (v == 0);
            end
            4'd2, 4'd3, 4'd4: begin
                if (o != 4'd3) ci = 0;
                c = (bi + ci) > ai;
                h = ((bi % 16) + ci) > (ai % 16);
                v = (ai - bi - ci + 512) % 256;
                z = (v == 0); n = 1;
                if (o == 4'd4) v = ai;
            end
            4'd5: begin
                h = (ai % 16) == 15; v = (ai + 1) % 256; z = (v == 0); n = 0;
            end
            4'd6: begin
                h = (ai % 16) == 0; v = (ai + 255) % 256; z = (v == 0); n = 1;
            end
            4'd7: begin
                if (n) begin
                    if (h) corr += 6;
                    if (c) corr += 96;
                    v = (ai - corr + 256) % 256;
                end else begin
                    if (h || (ai % 16) > 9) corr += 6;
                    if (c || ai > 153) begin corr += 96; c = 1; end
                    else c = 0;
                    v = (ai + corr) % 256;
                end
                h = 0; z = (v == 0);
            end
            4'd8, 4'd9, 4'd10: begin
                v = (o == 4'd8) ? int'(a & b) : (o == 4'd9) ? int'(a | b) : int'(a ^ b);
                z = (v == 0); n = 0; h = (o == 4'd8); c = 0;
            end
            default: v = ai;
        endcase
        return {v[7:0], z, n, h, c, 4'b0000};
    endfunction

    function automatic string tag_of(input logic [3:0] o, input logic [3:0] fl);
        case (o)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2, 4'd4: return "R3";
            4'd3: return "R4";
            4'd5, 4'd6: return "R5";
            4'd7: return fl[2] ? "R6" : "R7";
            4'd8, 4'd9, 4'd10: return "R9";
            default: return "R11";
        endcase
    endfunction

    // Driver: applies one operation and pushes the expected item
    task automatic drive(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                         input logic [3:0] fl, input logic e);
        item_t it;
        logic [15:0] r;
        @(negedge clk);
        op = o; a_in = a; b_in = b; flags_in = fl; en = e;
        r = ref_calc(o, a, b, fl);
        it.op = o; it.a = a; it.b = b; it.fl = fl;
        it.y = r[15:8]; it.f = r[7:0];
        if (e) begin acc_m = it.y; flg_m = it.f; end
        it.acc = acc_m; it.flg = flg_m;
        #1;
        q.push_back(it);
        sent++;
    endtask

    // Monitor: compares combinational outputs, then registers after the edge
    initial begin
        forever begin
            item_t it;
            wait (q.size() > 0);
            it = q.pop_front();
            checks++;
            if (result !== it.y || flags_out !== it.f) begin
                errors++;
                $display("FAIL %s op=%0d a=%h b=%h fl=%h: actual %h/%h expected %h/%h",
                         tag_of(it.op, it.fl), it.op, it.a, it.b, it.fl,
                         result, flags_out, it.y, it.f);
            end
            checks++;
            if (flags_out[3:0] !== 4'h0) begin
                errors++;
                $display("FAIL R10 low flag bits: actual %h expected 0", flags_out[3:0]);
            end
            if (it.op == 4'd7) begin
                checks++;
                if (flags_out[5] !== 1'b0 || flags_out[7] !== (result == 8'h00)) begin
                    errors++;
                    $display("FAIL R8 decimal adjust flags: actual %h expected h=0 z=%0d",
                             flags_out, (result == 8'h00));
                end
            end
            @(posedge clk);
            #1;
            checks++;
            if (acc_q !== it.acc || flag_q !== it.flg) begin
                errors++;
                $display("FAIL R12 write-back: actual %h/%h expected %h/%h",
                         acc_q, flag_q, it.acc, it.flg);
            end
            seen++;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R12 watchdog expired: actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int k;
        k = 0;
        repeat (3) @(posedge clk);
        // R13: reset state
        checks++;
        if (acc_q !== 8'h00 || flag_q !== 8'h00) begin
            errors++;
            $display("FAIL R13 reset: actual %h/%h expected 00/00", acc_q, flag_q);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // Unary operations: every A against every flag nibble (R5, R6, R7, R8)
        for (int o = 5; o <= 7; o++) begin
            for (int a = 0; a < 256; a++) begin
                for (int f = 0; f < 16; f++) begin
                    drive(4'(o), 8'(a), 8'(a * 3 + 1), 4'(f), (k % 7) != 0);
                    k++;
                end
            end
        end

        // Binary operations: every A against an operand spread and both carries
        // (R1, R2, R3, R4, R9, R10)
        for (int o = 0; o <= 10; o++) begin
            if (o >= 5 && o <= 7) continue;
            for (int a = 0; a < 256; a++) begin
                for (int j = 0; j < 18; j++) begin
                    int b;
                    b = (j < 16) ? ((j * 37 + 5) % 256) : ((j == 16) ? 0 : 255);
                    drive(4'(o), 8'(a), 8'(b), 4'h0, (k % 7) != 0);
                    k++;
                    drive(4'(o), 8'(a), 8'(b), 4'hF, (k % 7) != 0);
                    k++;
                end
            end
        end

        // Spare selects pass A and flags (R11)
        for (int o = 11; o < 16; o++) begin
            for (int f = 0; f < 16; f++) begin
                drive(4'(o), 8'(f * 17 + o), 8'hA5, 4'(f), 1'b1);
                drive(4'(o), 8'(f * 11), 8'h5A, 4'(15 - f), 1'b0);
            end
        end

        wait (seen == sent);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule